// File: doc/BRIEF.md
# SMBus transaction sequencer

This block carries out one complete SMBus-style transfer by directing a byte-level I2C master engine. The host presents one request in a single cycle. A request holds a 7-bit target address, a direction flag, a command byte, a transfer kind and, for block transfers, a byte count. The sequencer then steps through the bus phases. It issues start, stop and byte-transmit commands to the engine. It also drives a level that tells the engine to answer the next received byte with not-acknowledge. Each step is taken on an engine event: byte finished, negative acknowledge or bus error. A level input reports whether the engine still holds the bus as master.

Outgoing data comes from an internal byte buffer, and incoming data is stored there. The host fills the buffer through a write port before the transfer and reads it back through a combinational read port afterwards. When the sequencer returns to idle it pulses `done` and holds a result code. A flag tells the surrounding logic that the engine must be reinitialised after a fault.

Top module: `smbus_seq`

## Requirements
- R1: While reset is held and after its release: `busy`, `done`, `idle_warn`, `reset_req`, `eng_nak_next` and all engine command outputs are 0, and `result` is 0 (OK).
- R2: Kinds 2 (byte-data), 3 (word) and 4 (block) begin with one `eng_start`. The first transmitted byte is the address shifted left by one with bit 0 = 0, and the second is the command byte.
- R3: After the command byte, a read issues `eng_start` and transmits {address, 1} in the same cycle. A write goes straight to data bytes.
- R4: Kinds 0 (quick) and 1 (byte) send one start and then {address, read flag} with no command phase. A byte write then sends the command byte as its single data byte, and a quick write sends no data.
- R5: `eng_nak_next` is 1 while the final read byte is received and 0 while every earlier byte is received. This includes a one-byte read.
- R6: A read of n bytes (1 for kinds 1 and 2, 2 for kind 3, the request length for kind 4) stores the bytes at buffer indices 0..n-1 in arrival order, so a word is low byte first. The final byte issues one stop, and the result is 0 (OK).
- R7: A write sends buffer indices 0..n-1 in order, one byte per finished byte. The byte-finished event that follows the last byte issues one stop, and the result is 0.
- R8: A negative acknowledge in any busy state issues one stop and one `eng_clr_flags` pulse, returns to idle with result 1 (no device), and leaves `reset_req` at 0.
- R9: A bus error, or any event that arrives while `ev_master` is 0, ends the transfer with result 2 (I/O error), no stop and `reset_req` = 1. The next accepted request clears `reset_req`.
- R10: A request is rejected without any engine command if its kind is above 4, its block length is 0 or above 32, or it is a read of kind 0. Rejection gives result 3 and a `done` pulse in the cycle after the request.
- R11: If no engine event arrives for TIMEOUT_CYCLES cycles after acceptance or after the last event, the transfer ends with result 2 and `reset_req` = 1. `done` appears TIMEOUT_CYCLES cycles after the accepting edge.
- R12: An engine event while idle raises `idle_warn` for one cycle and issues no command. A request while busy is ignored. `done` lasts exactly one cycle.
- R13: When a host buffer write and the storing of a received byte target the same index in the same cycle, the received byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_kind | input | 3 | 0 quick, 1 byte, 2 byte-data, 3 word, 4 block |
| req_read | input | 1 | 1 = read |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command byte (data byte for a byte write) |
| req_len | input | LEN_W (6) | Byte count for block transfers |
| buf_wr_en | input | 1 | Host buffer write strobe |
| buf_wr_idx | input | IDX_W (5) | Host buffer write index |
| buf_wr_data | input | 8 | Host buffer write data |
| buf_rd_idx | input | IDX_W (5) | Host buffer read index |
| buf_rd_data | output | 8 | Buffer content at `buf_rd_idx` |
| eng_start | output | 1 | Engine: generate (repeated) start |
| eng_stop | output | 1 | Engine: generate stop |
| eng_nak_next | output | 1 | Engine: not-acknowledge the next received byte |
| eng_clr_flags | output | 1 | Engine: clear its sticky status flags |
| eng_tx_valid | output | 1 | Engine: transmit `eng_tx_data` |
| eng_tx_data | output | 8 | Byte to transmit |
| eng_rx_data | input | 8 | Received byte, valid with `ev_byte_done` |
| ev_byte_done | input | 1 | Engine event: byte phase finished |
| ev_bus_err | input | 1 | Engine event: bus error |
| ev_nack | input | 1 | Engine event: negative acknowledge |
| ev_master | input | 1 | Level: engine holds the bus as master |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on return to idle |
| result | output | 2 | 0 OK, 1 no device, 2 I/O error, 3 invalid |
| reset_req | output | 1 | Engine needs reinitialising |
| idle_warn | output | 1 | Event seen while idle |

## Verification
The sequencer's internal store of a received byte and the host write port can both hit the buffer in the same cycle. The bench provokes this during a block read. In the very cycle it presents a byte-finished event carrying received data, it also drives a host write of a different value to the index that byte is destined for. After the transfer the index is read back through the read port, and it must hold the received value. The neighbouring indices are checked as well, to show the rest of the transfer was not disturbed.

// File: rtl/smbus_seq.sv
module smbus_seq #(
  parameter int BUF_DEPTH      = 32,
  parameter int MAX_BLOCK      = 32,
  parameter int TIMEOUT_CYCLES = 40_000_000,
  localparam int IDX_W = $clog2(BUF_DEPTH),
  localparam int LEN_W = $clog2(MAX_BLOCK + 1),
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic             req_read,
  input  logic [6:0]       req_addr,
  input  logic [7:0]       req_cmd,
  input  logic [LEN_W-1:0] req_len,
  input  logic             buf_wr_en,
  input  logic [IDX_W-1:0] buf_wr_idx,
  input  logic [7:0]       buf_wr_data,
  input  logic [IDX_W-1:0] buf_rd_idx,
  output logic [7:0]       buf_rd_data,
  output logic             eng_start,
  output logic             eng_stop,
  output logic             eng_nak_next,
  output logic             eng_clr_flags,
  output logic             eng_tx_valid,
  output logic [7:0]       eng_tx_data,
  input  logic [7:0]       eng_rx_data,
  input  logic             ev_byte_done,
  input  logic             ev_bus_err,
  input  logic             ev_nack,
  input  logic             ev_master,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic             reset_req,
  output logic             idle_warn
);
  localparam logic [2:0] K_QUICK = 3'd0, K_BYTE = 3'd1, K_BDATA = 3'd2,
                         K_WORD  = 3'd3, K_BLOCK = 3'd4;
  localparam logic [1:0] R_OK = 2'd0, R_NODEV = 2'd1, R_IOERR = 2'd2, R_INVAL = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_RSTART, S_QUICK, S_READ, S_WRITE} state_t;

  state_t           st;
  logic [7:0]       addr_byte, cmd_q;
  logic             cmd_is_data;
  logic [LEN_W-1:0] left;
  logic [IDX_W-1:0] ptr;
  logic [TMR_W-1:0] tmr;
  logic [7:0]       mem [BUF_DEPTH];
  logic [LEN_W-1:0] req_n;
  logic             req_ok, ev_any, io_fail, rx_store;
  logic [7:0]       wr_byte;

  assign busy        = (st != S_IDLE);
  assign ev_any      = ev_byte_done | ev_bus_err | ev_nack;
  assign io_fail     = ev_bus_err | ~ev_master;
  assign rx_store    = (st == S_READ) && ev_any && !io_fail && !ev_nack;
  assign wr_byte     = cmd_is_data ? cmd_q : mem[ptr];
  assign buf_rd_data = mem[buf_rd_idx];

  always_comb begin
    req_ok = 1'b1;
    req_n  = '0;
    case (req_kind)
      K_QUICK:         req_n = '0;
      K_BYTE, K_BDATA: req_n = LEN_W'(1);
      K_WORD:          req_n = LEN_W'(2);
      K_BLOCK: begin
        req_n = req_len;
        if (req_len == '0 || req_len > LEN_W'(MAX_BLOCK)) req_ok = 1'b0;
      end
      default:         req_ok = 1'b0;
    endcase
    if (req_n == '0 && req_read) req_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (buf_wr_en) mem[buf_wr_idx] <= buf_wr_data;
    if (rx_store)  mem[ptr] <= eng_rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_byte <= '0; cmd_q <= '0; cmd_is_data <= 1'b0;
      left <= '0; ptr <= '0; tmr <= '0;
      eng_start <= 1'b0; eng_stop <= 1'b0; eng_nak_next <= 1'b0;
      eng_clr_flags <= 1'b0; eng_tx_valid <= 1'b0; eng_tx_data <= '0;
      done <= 1'b0; result <= R_OK; reset_req <= 1'b0; idle_warn <= 1'b0;
    end else begin
      eng_start <= 1'b0; eng_stop <= 1'b0; eng_clr_flags <= 1'b0;
      eng_tx_valid <= 1'b0; done <= 1'b0; idle_warn <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          if (!req_ok) begin
            result <= R_INVAL;
            done   <= 1'b1;
          end else begin
            addr_byte    <= {req_addr, req_read};
            cmd_q        <= req_cmd;
            cmd_is_data  <= (req_kind == K_BYTE) && !req_read;
            left         <= req_n;
            ptr          <= '0;
            tmr          <= '0;
            reset_req    <= 1'b0;
            eng_nak_next <= 1'b0;
            eng_start    <= 1'b1;
            st <= (req_kind == K_QUICK || req_kind == K_BYTE) ? S_QUICK : S_ADDR;
          end
        end else if (ev_any) begin
          idle_warn <= 1'b1;
        end
      end else if (ev_any) begin
        tmr <= '0;
        if (io_fail) begin
          st <= S_IDLE; result <= R_IOERR; reset_req <= 1'b1; done <= 1'b1;
        end else if (ev_nack) begin
          st <= S_IDLE; result <= R_NODEV; done <= 1'b1;
          eng_stop <= 1'b1; eng_clr_flags <= 1'b1;
        end else begin
          case (st)
            S_ADDR: begin
              eng_tx_valid <= 1'b1;
              eng_tx_data  <= {addr_byte[7:1], 1'b0};
              st <= S_CMD;
            end
            S_CMD: begin
              eng_tx_valid <= 1'b1;
              eng_tx_data  <= cmd_q;
              st <= addr_byte[0] ? S_RSTART : S_WRITE;
            end
            S_RSTART, S_QUICK: begin
              if (st == S_RSTART) eng_start <= 1'b1;
              eng_tx_valid <= 1'b1;
              eng_tx_data  <= addr_byte;
              if (addr_byte[0]) begin
                eng_nak_next <= (left == LEN_W'(1));
                st <= S_READ;
              end else begin
                st <= S_WRITE;
              end
            end
            S_READ: begin
              eng_nak_next <= (left == LEN_W'(2));
              if (left == LEN_W'(1)) begin
                eng_stop <= 1'b1; st <= S_IDLE; result <= R_OK; done <= 1'b1;
              end
              ptr  <= ptr + 1'b1;
              left <= left - 1'b1;
            end
            S_WRITE: begin
              if (left == '0) begin
                eng_stop <= 1'b1; st <= S_IDLE; result <= R_OK; done <= 1'b1;
              end else begin
                eng_tx_valid <= 1'b1;
                eng_tx_data  <= wr_byte;
                ptr  <= ptr + 1'b1;
                left <= left - 1'b1;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end else if (tmr == TMR_W'(TIMEOUT_CYCLES - 1)) begin
        st <= S_IDLE; result <= R_IOERR; reset_req <= 1'b1; done <= 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !req_valid |=> !eng_start && !eng_tx_valid && !eng_stop);
  a_r3_restart_reads: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && eng_tx_valid |-> eng_tx_data[0]);
  a_r8_nack_stops: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ev_nack && !ev_bus_err && ev_master
      |=> eng_stop && eng_clr_flags && !busy && result == R_NODEV && !reset_req);
  a_r9_io_fault: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ev_any && (ev_bus_err || !ev_master)
      |=> !eng_stop && !busy && reset_req && result == R_IOERR);
  a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid && !req_ok |=> done && !busy && !eng_start && result == R_INVAL);
endmodule

// File: tb/smbus_seq_tb_top.sv
`timescale 1ns/1ps
module smbus_seq_tb_top;
  localparam int TMO = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_valid = 0, req_read = 0;
  logic [2:0] req_kind = 0;
  logic [6:0] req_addr = 0;
  logic [7:0] req_cmd = 0;
  logic [5:0] req_len = 0;
  logic       buf_wr_en = 0;
  logic [4:0] buf_wr_idx = 0, buf_rd_idx = 0;
  logic [7:0] buf_wr_data = 0, buf_rd_data;
  logic       eng_start, eng_stop, eng_nak_next, eng_clr_flags, eng_tx_valid;
  logic [7:0] eng_tx_data, eng_rx_data = 0;
  logic       ev_byte_done = 0, ev_bus_err = 0, ev_nack = 0, ev_master = 1;
  logic       busy, done, reset_req, idle_warn;
  logic [1:0] result;

  smbus_seq #(.TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_read(req_read), .req_addr(req_addr), .req_cmd(req_cmd), .req_len(req_len),
    .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data),
    .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
    .eng_start(eng_start), .eng_stop(eng_stop), .eng_nak_next(eng_nak_next),
    .eng_clr_flags(eng_clr_flags), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
    .eng_rx_data(eng_rx_data), .ev_byte_done(ev_byte_done), .ev_bus_err(ev_bus_err),
    .ev_nack(ev_nack), .ev_master(ev_master), .busy(busy), .done(done),
    .result(result), .reset_req(reset_req), .idle_warn(idle_warn));

  // {kind[3], read, len[6], addr[7], cmd[8], expected tx bytes[6], expected starts[2]}
  localparam logic [32:0] VEC [9] = '{
    {3'd0, 1'b0, 6'd0, 7'h2A, 8'h00, 6'd1, 2'd1},
    {3'd1, 1'b0, 6'd0, 7'h11, 8'h5C, 6'd2, 2'd1},
    {3'd1, 1'b1, 6'd0, 7'h11, 8'h00, 6'd1, 2'd1},
    {3'd2, 1'b0, 6'd0, 7'h50, 8'h10, 6'd3, 2'd1},
    {3'd2, 1'b1, 6'd0, 7'h50, 8'h10, 6'd3, 2'd2},
    {3'd3, 1'b0, 6'd0, 7'h48, 8'h02, 6'd4, 2'd1},
    {3'd3, 1'b1, 6'd0, 7'h48, 8'h03, 6'd3, 2'd2},
    {3'd4, 1'b0, 6'd5, 7'h3C, 8'h80, 6'd7, 2'd1},
    {3'd4, 1'b1, 6'd4, 7'h3C, 8'h81, 6'd3, 2'd2}
  };

  int n_chk = 0, n_bad = 0;
  logic [7:0] tx_log [64];
  bit         nak_log [64];
  logic [7:0] bmodel [32];
  int ntx, nst, nsp, nclr, nrx, ncyc;
  logic [1:0] res_seen;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic load_buf(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      buf_wr_en = 1; buf_wr_idx = 5'(i); buf_wr_data = 8'(8'h30 + i * 7 + seed);
      bmodel[i] = 8'(8'h30 + i * 7 + seed);
    end
    @(negedge clk);
    buf_wr_en = 0;
  endtask

  task automatic read_buf(input int idx, output logic [7:0] v);
    buf_rd_idx = 5'(idx);
    #1;
    v = buf_rd_data;
  endtask

  // inj_ty: 0 none, 1 nack, 2 bus error, 3 master lost, 4 engine silent
  task automatic run_txn(input logic [2:0] kind, input logic rd, input logic [5:0] len,
                         input logic [6:0] addr, input logic [7:0] cmd, input int inj_ev,
                         input int inj_ty, input int collide, input int busy_req);
    bit pend, in_rd, exp_addr, silent, gave;
    int evn;
    pend = 0; in_rd = 0; exp_addr = 0; silent = 0; gave = 0; evn = 0;
    ntx = 0; nst = 0; nsp = 0; nclr = 0; nrx = 0; ncyc = 0; res_seen = 'x;
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_read = rd; req_len = len; req_addr = addr; req_cmd = cmd;
    while (1) begin
      @(negedge clk);
      ncyc++;
      req_valid = 0; ev_byte_done = 0; ev_bus_err = 0; ev_nack = 0; ev_master = 1; buf_wr_en = 0;
      if (eng_start) begin nst++; exp_addr = 1; end
      if (eng_stop) nsp++;
      if (eng_clr_flags) nclr++;
      if (eng_tx_valid) begin
        tx_log[ntx] = eng_tx_data; ntx++;
        if (exp_addr && eng_tx_data[0]) in_rd = 1;
        exp_addr = 0; pend = 1;
      end else if (eng_start) pend = 1;
      if (gave && in_rd && !eng_stop && !eng_tx_valid) pend = 1;
      gave = 0;
      if (done) begin res_seen = result; break; end
      if (busy_req == ncyc) begin req_valid = 1; req_kind = 3'd7; end
      if (pend && !silent) begin
        pend = 0; evn++;
        if (evn == inj_ev && inj_ty == 4) silent = 1;
        else begin
          gave = 1;
          if (evn == inj_ev && inj_ty == 1) ev_nack = 1;
          else if (evn == inj_ev && inj_ty == 2) ev_bus_err = 1;
          else begin
            ev_byte_done = 1;
            if (evn == inj_ev && inj_ty == 3) ev_master = 0;
            if (in_rd) begin
              eng_rx_data = 8'(8'hC0 ^ nrx);
              nak_log[nrx] = eng_nak_next;
              if (collide == nrx) begin
                buf_wr_en = 1; buf_wr_idx = 5'(nrx); buf_wr_data = 8'h55;
              end
              nrx++;
            end
          end
        end
      end
      if (ncyc > 2000) break;
    end
    req_valid = 0; ev_byte_done = 0; ev_bus_err = 0; ev_nack = 0; ev_master = 1; buf_wr_en = 0;
  endtask

  task automatic verify(input logic [2:0] kind, input logic rd, input logic [5:0] len,
                        input logic [6:0] addr, input logic [7:0] cmd,
                        input int ntx_t, input int nst_t);
    logic [7:0] ex [40];
    logic [7:0] v;
    int n, ne, nse;
    string rq;
    n = (kind == 0) ? 0 : (kind == 3) ? 2 : (kind == 4) ? int'(len) : 1;
    if (kind <= 1) begin
      rq = "R4"; ex[0] = {addr, rd}; ne = 1; nse = 1;
      if (!rd && kind == 1) begin ex[1] = cmd; ne = 2; end
    end else begin
      rq = rd ? "R3" : "R2"; ex[0] = {addr, 1'b0}; ex[1] = cmd; ne = 2;
      if (rd) begin ex[2] = {addr, 1'b1}; ne = 3; nse = 2; end
      else begin
        nse = 1;
        for (int i = 0; i < n; i++) begin ex[ne] = bmodel[i]; ne++; end
      end
    end
    chk(rq, "tx count", ntx, ne);
    chk(rq, "tx count vs table", ntx, ntx_t);
    for (int i = 0; i < ne && i < ntx; i++) chk(rq, "tx byte", int'(tx_log[i]), int'(ex[i]));
    chk(rq, "start count", nst, nse);
    chk(rq, "start count vs table", nst, nst_t);
    chk(rd ? "R6" : "R7", "stop count", nsp, 1);
    chk(rd ? "R6" : "R7", "result ok", int'(res_seen), 0);
    if (rd) begin
      chk("R6", "rx count", nrx, n);
      for (int i = 0; i < n && i < nrx; i++) chk("R5", "nak flag per byte", int'(nak_log[i]), int'(i == n - 1));
      for (int i = 0; i < n; i++) begin
        read_buf(i, v);
        chk("R6", "stored byte", int'(v), int'(8'hC0 ^ i));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [32:0] e;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "cmd outputs in reset", {eng_start, eng_stop, eng_tx_valid, eng_clr_flags, eng_nak_next}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done/warn after reset", {done, idle_warn}, 0);
    chk("R1", "result after reset", int'(result), 0);
    chk("R1", "reset_req after reset", reset_req, 0);

    for (int k = 0; k < 9; k++) begin
      e = VEC[k];
      load_buf(8, k);
      run_txn(e[32:30], e[29], e[28:23], e[22:16], e[15:8], 0, 0, -1, -1);
      verify(e[32:30], e[29], e[28:23], e[22:16], e[15:8], int'(e[7:2]), int'(e[1:0]));
    end
    @(negedge clk);
    chk("R12", "done one cycle", done, 0);

    run_txn(3'd4, 1'b1, 6'd32, 7'h21, 8'h44, 0, 0, -1, -1);
    verify(3'd4, 1'b1, 6'd32, 7'h21, 8'h44, 3, 2);

    run_txn(3'd5, 1'b0, 6'd1, 7'h10, 8'h00, 0, 0, -1, -1);
    chk("R10", "bad kind result", int'(res_seen), 3);
    chk("R10", "bad kind latency", ncyc, 1);
    chk("R10", "bad kind no start", nst + ntx, 0);
    run_txn(3'd4, 1'b0, 6'd0, 7'h10, 8'h00, 0, 0, -1, -1);
    chk("R10", "block len 0 result", int'(res_seen), 3);
    chk("R10", "block len 0 no start", nst + ntx, 0);
    run_txn(3'd4, 1'b1, 6'd33, 7'h10, 8'h00, 0, 0, -1, -1);
    chk("R10", "block len 33 result", int'(res_seen), 3);
    chk("R10", "block len 33 no start", nst + ntx, 0);
    run_txn(3'd0, 1'b1, 6'd0, 7'h10, 8'h00, 0, 0, -1, -1);
    chk("R10", "quick read result", int'(res_seen), 3);
    chk("R10", "quick read no start", nst + ntx, 0);

    run_txn(3'd2, 1'b0, 6'd0, 7'h50, 8'h10, 2, 1, -1, -1);
    chk("R8", "nack result", int'(res_seen), 1);
    chk("R8", "nack stop", nsp, 1);
    chk("R8", "nack clear flags", nclr, 1);
    chk("R8", "nack tx count", ntx, 1);
    chk("R8", "nack reset_req", reset_req, 0);

    run_txn(3'd3, 1'b0, 6'd0, 7'h48, 8'h02, 3, 2, -1, -1);
    chk("R9", "bus error result", int'(res_seen), 2);
    chk("R9", "bus error no stop", nsp, 0);
    chk("R9", "bus error reset_req", reset_req, 1);
    chk("R9", "bus error tx count", ntx, 2);
    run_txn(3'd0, 1'b0, 6'd0, 7'h2A, 8'h00, 0, 0, -1, -1);
    chk("R9", "reset_req cleared by new request", reset_req, 0);
    chk("R9", "following quick write ok", int'(res_seen), 0);

    run_txn(3'd0, 1'b0, 6'd0, 7'h2A, 8'h00, 1, 3, -1, -1);
    chk("R9", "master lost result", int'(res_seen), 2);
    chk("R9", "master lost reset_req", reset_req, 1);
    chk("R9", "master lost no tx", ntx, 0);

    run_txn(3'd2, 1'b0, 6'd0, 7'h50, 8'h10, 1, 4, -1, 5);
    chk("R11", "timeout result", int'(res_seen), 2);
    chk("R11", "timeout latency", ncyc, TMO + 1);
    chk("R11", "timeout reset_req", reset_req, 1);
    chk("R12", "busy request ignored (no extra start)", nst, 1);

    @(negedge clk);
    ev_byte_done = 1;
    @(negedge clk);
    ev_byte_done = 0;
    chk("R12", "idle event warning", idle_warn, 1);
    chk("R12", "idle event no command", {eng_start, eng_stop, eng_tx_valid}, 0);
    chk("R12", "idle event result unchanged", int'(result), 2);
    chk("R12", "idle event stays idle", busy, 0);
    @(negedge clk);
    chk("R12", "warning one cycle", idle_warn, 0);

    run_txn(3'd4, 1'b1, 6'd3, 7'h66, 8'h01, 0, 0, 1, -1);
    chk("R13", "collision result", int'(res_seen), 0);
    read_buf(1, v);
    chk("R13", "received byte wins collision", int'(v), 8'hC1);
    read_buf(0, v);
    chk("R13", "neighbour index 0", int'(v), 8'hC0);
    read_buf(2, v);
    chk("R13", "neighbour index 2", int'(v), 8'hC2);

    summary();
  end
endmodule